// File: doc/BRIEF.md
# Time-of-Day Keeper with Schedule Strobes

This block keeps a 24-hour time of day from a slow, free-running system clock. A prescaler counts clock cycles up to one minute. On the last cycle of each minute, the minute counter advances. The hour advances when the minutes roll over, and both return to zero at the end of the day. Minutes and hours come out as plain binary values. Display decoding and temperature control are left to the blocks that consume them.

The block also raises two schedule strobes, each one clock cycle wide. Each strobe fires at a fixed hour on the hour, and a neighbouring setpoint block uses them to load its programmed values. The cycles per minute and both trigger hours are parameters. The default is 7200 cycles per minute, which suits a 120 Hz clock, with triggers at 09:00 and 19:00. A simulation can shorten the minute to a handful of cycles and move the triggers to early hours.

Top module: `tod_keeper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is time 00:00 with both strobes low, and the cycle prescaler returns to zero.
- R2: After reset is released, the minute value advances by one on every `TICKS_PER_MIN`-th rising edge and holds between those edges. The first advance comes exactly `TICKS_PER_MIN` edges after release.
- R3: Minutes count 0 to 59 in binary on `minute_o`. An advance from 59 gives minute 0 and increments `hour_o` by one.
- R4: Hours count 0 to 23 in binary on `hour_o`. An advance from 23:59 gives 00:00.
- R5: `sched_a_o` is high for exactly one cycle: the first cycle in which the outputs show hour `TRIG_HOUR_A` with minute 0.
- R6: `sched_b_o` is high for exactly one cycle: the first cycle in which the outputs show hour `TRIG_HOUR_B` with minute 0.
- R7: Outside those cycles both strobes stay low. This includes the 00:00 state that reset produces, so each strobe fires at most once per day.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| minute_o | output | 6 | Current minute, binary 0..59 |
| hour_o | output | 5 | Current hour, binary 0..23 |
| sched_a_o | output | 1 | One-cycle strobe on reaching `TRIG_HOUR_A`:00 |
| sched_b_o | output | 1 | One-cycle strobe on reaching `TRIG_HOUR_B`:00 |

## Verification
The time outputs and both strobes are registered on the same edge. After reset is released, the state seen after edge k therefore shows minute-of-day floor(k / TICKS_PER_MIN) mod 1440. A strobe is expected only when k is a non-zero multiple of the minute length that lands on its trigger hour. The bench counts edges since the last reset release and samples every output on the falling edge after each rising edge, so a result is compared in the same cycle it becomes due. One shortened configuration is swept through a full day and across midnight. A reset in the middle of a minute then checks that the count restarts from zero.

// File: rtl/tod_pkg.sv
// Package: shared widths and types for the time-of-day keeper.
// Assumes a 24-hour day of 60-minute hours.
package tod_pkg;
    localparam int MIN_W        = 6;
    localparam int HR_W         = 5;
    localparam int MINS_PER_HR  = 60;
    localparam int HRS_PER_DAY  = 24;
    localparam int NUM_STROBES  = 2;

    typedef logic [MIN_W-1:0] minute_t;
    typedef logic [HR_W-1:0]  hour_t;
endpackage

// File: rtl/tod_prescaler.sv
// Module: tod_prescaler
// Counts clock cycles within one minute and flags the final cycle.
// Assumes TICKS_PER_MIN >= 2. Reset is synchronous and active low.
module tod_prescaler #(
    parameter int TICKS_PER_MIN = 7200
) (
    input  logic clk,
    input  logic rst_n,
    output logic minute_adv_o
);
    localparam int CNT_W    = $clog2(TICKS_PER_MIN + 1);
    localparam int LAST_CNT = TICKS_PER_MIN - 1;

    logic [CNT_W-1:0] cnt_q;

    // Flag the last cycle of the minute.
    always_comb minute_adv_o = (cnt_q == CNT_W'(LAST_CNT));

    // Step the cycle count, restarting at each minute boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (minute_adv_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TICKS_PER_MIN));

    assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        minute_adv_o |=> (cnt_q == '0));
endmodule

// File: rtl/tod_clock_counter.sv
// Module: tod_clock_counter
// Keeps minutes and hours. Both advance on the prescaler's minute flag.
// Assumes a single-cycle advance pulse. Reset is synchronous and active low.
module tod_clock_counter
    import tod_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    minute_adv_i,
    output minute_t minute_o,
    output hour_t   hour_o
);
    localparam minute_t LAST_MIN = minute_t'(MINS_PER_HR - 1);
    localparam hour_t   LAST_HR  = hour_t'(HRS_PER_DAY - 1);

    minute_t min_q;
    hour_t   hr_q;

    // Advance minutes, carry into hours, wrap at end of day.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '0;
            hr_q  <= '0;
        end else if (minute_adv_i) begin
            if (min_q == LAST_MIN) begin
                min_q <= '0;
                hr_q  <= (hr_q == LAST_HR) ? '0 : hr_q + 1'b1;
            end else begin
                min_q <= min_q + 1'b1;
            end
        end
    end

    assign minute_o = min_q;
    assign hour_o   = hr_q;

    assert_min_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        min_q <= LAST_MIN);

    assert_hr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hr_q <= LAST_HR);

    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !minute_adv_i |=> ($stable(min_q) && $stable(hr_q)));

    assert_hour_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_adv_i && min_q == LAST_MIN && hr_q != LAST_HR)
        |=> (min_q == '0 && hr_q == $past(hr_q) + 1'b1));

    assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_adv_i && min_q == LAST_MIN && hr_q == LAST_HR)
        |=> (min_q == '0 && hr_q == '0));
endmodule

// File: rtl/tod_sched_strobe.sv
// Module: tod_sched_strobe
// Raises a one-cycle strobe on the cycle the time first shows TRIG_HOUR:00.
// It watches for the last minute of the previous hour and a minute advance.
// Assumes TRIG_HOUR is in 0..23. Reset is synchronous and active low.
module tod_sched_strobe
    import tod_pkg::*;
#(
    parameter int TRIG_HOUR = 9
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    minute_adv_i,
    input  minute_t minute_i,
    input  hour_t   hour_i,
    output logic    strobe_o
);
    localparam int    PREV_HOUR_I = (TRIG_HOUR == 0) ? HRS_PER_DAY - 1 : TRIG_HOUR - 1;
    localparam hour_t PREV_HOUR   = hour_t'(PREV_HOUR_I);
    localparam minute_t LAST_MIN  = minute_t'(MINS_PER_HR - 1);

    logic stb_q;

    // Register the strobe alongside the edge that enters the trigger hour.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stb_q <= 1'b0;
        else
            stb_q <= minute_adv_i && (minute_i == LAST_MIN) && (hour_i == PREV_HOUR);
    end

    assign strobe_o = stb_q;

    assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);
endmodule

// File: rtl/tod_keeper.sv
// Module: tod_keeper (top)
// 24-hour time keeper with two schedule strobes.
// Assumes TICKS_PER_MIN >= 2 and trigger hours in 0..23.
// Reset is synchronous and active low.
module tod_keeper
    import tod_pkg::*;
#(
    parameter int TICKS_PER_MIN = 7200,
    parameter int TRIG_HOUR_A   = 9,
    parameter int TRIG_HOUR_B   = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [5:0] minute_o,
    output logic [4:0] hour_o,
    output logic       sched_a_o,
    output logic       sched_b_o
);
    logic    minute_adv;
    minute_t min_w;
    hour_t   hr_w;
    logic [NUM_STROBES-1:0] stb_w;

    tod_prescaler #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_presc (
        .clk          (clk),
        .rst_n        (rst_n),
        .minute_adv_o (minute_adv)
    );

    tod_clock_counter u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .minute_adv_i (minute_adv),
        .minute_o     (min_w),
        .hour_o       (hr_w)
    );

    // One strobe generator for each trigger hour.
    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
        localparam int TRIG = (g == 0) ? TRIG_HOUR_A : TRIG_HOUR_B;
        tod_sched_strobe #(.TRIG_HOUR(TRIG)) u_stb (
            .clk          (clk),
            .rst_n        (rst_n),
            .minute_adv_i (minute_adv),
            .minute_i     (min_w),
            .hour_i       (hr_w),
            .strobe_o     (stb_w[g])
        );
    end

    assign minute_o  = min_w;
    assign hour_o    = hr_w;
    assign sched_a_o = stb_w[0];
    assign sched_b_o = stb_w[1];

    assert_stb_a_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sched_a_o |-> (min_w == '0 && hr_w == hour_t'(TRIG_HOUR_A)));

    assert_stb_b_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sched_b_o |-> (min_w == '0 && hr_w == hour_t'(TRIG_HOUR_B)));

    assert_stb_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_a_o || sched_b_o) |-> !$stable(hr_w));
endmodule

// File: tb/test_tod_keeper.sv
// Bench: shortened configuration, full-day sweep, plus a reset mid-minute.
module test_tod_keeper;
    localparam int CLK_PERIOD = 10;
    localparam int TPM        = 4;
    localparam int TA         = 2;
    localparam int TB         = 3;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] minute_o;
    logic [4:0] hour_o;
    logic       sched_a_o, sched_b_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    tod_keeper #(.TICKS_PER_MIN(TPM), .TRIG_HOUR_A(TA), .TRIG_HOUR_B(TB)) i_tod_keeper (
        .clk       (clk),
        .rst_n     (rst_n),
        .minute_o  (minute_o),
        .hour_o    (hour_o),
        .sched_a_o (sched_a_o),
        .sched_b_o (sched_b_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: reset state sampled after an edge with rst_n low
    task automatic check_reset();
        chk("R1", "minute", int'(minute_o), 0);
        chk("R1", "hour", int'(hour_o), 0);
        chk("R1", "strobe a", int'(sched_a_o), 0);
        chk("R1", "strobe b", int'(sched_b_o), 0);
    endtask

    // Expected state after k edges since reset release.
    task automatic check_at(input int k);
        int tot, em, eh, ea, eb;
        bit edge_min;
        string tm;
        tot = (k / TPM) % 1440;
        em = tot % 60;
        eh = tot / 60;
        edge_min = (k > 0) && (k % TPM == 0);
        ea = (edge_min && tot == TA * 60) ? 1 : 0;
        eb = (edge_min && tot == TB * 60) ? 1 : 0;
        if (edge_min && tot == 0)      tm = "R4";
        else if (edge_min && em == 0)  tm = "R3";
        else                           tm = "R2";
        chk(tm, "minute", int'(minute_o), em);
        chk(tm, "hour", int'(hour_o), eh);
        chk(ea ? "R5" : "R7", "strobe a", int'(sched_a_o), ea);
        chk(eb ? "R6" : "R7", "strobe b", int'(sched_b_o), eb);
    endtask

    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_reset();
        end
        rst_n = 1'b1;
        // Full day plus a few minutes across midnight.
        for (int k = 1; k <= TPM * (1440 + 3); k++) begin
            @(negedge clk);
            check_at(k);
        end
        // Reset part-way through a minute (R1, R2 restart).
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check_reset();
        end
        rst_n = 1'b1;
        for (int k = 1; k <= TPM * 200; k++) begin
            @(negedge clk);
            check_at(k);
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule